// File: doc/BRIEF.md
# Twelve-bit coefficient byte packer

This block turns a set of stored polynomials with 12-bit coefficients into a byte stream for two key buffers. The coefficients of each polynomial are taken two at a time. Each pair is emitted as three bytes, with the middle byte split between the top nibble of the first coefficient and the bottom nibble of the second. The block walks `2*HALF_POLYS` polynomials in order. The first `HALF_POLYS` are read from the public source region and written to the public key buffer. The rest are read from the secret source region, at index `poly - HALF_POLYS`, and written to the secret key buffer.

The source storage has one read port with a registered output: data appears the cycle after the read is issued. The block therefore spreads the two coefficient reads of a pair across that pair's three-byte window. The first coefficient of the next pair is fetched during the last byte of the current pair, and one priming read opens the run. After that, one byte is written every cycle. A one-cycle `done` pulse follows the final byte.

The reset `rst_n` is asynchronous and active low, and its release is expected to be synchronous to `clk`.

Top module: `coef_byte_packer`

## Requirements
- R1: After reset, `busy`, `done`, `src_rd_en` and `key_wr_en` are all 0, and no read or write is issued while `busy` is 0.
- R2: For a pair (c0, c1), where c0 is the even-indexed coefficient, the first byte written is c0[7:0].
- R3: The second byte of a pair is {c1[3:0], c0[11:8]}.
- R4: The third byte of a pair is c1[11:4].
- R5: Polynomials 0..HALF_POLYS-1 are read with `src_rd_sel`=0 and written with `key_wr_sel`=0. Polynomials HALF_POLYS..2*HALF_POLYS-1 are read with `src_rd_sel`=1, at region index `poly-HALF_POLYS`, and written with `key_wr_sel`=1. The source read address is index*COEFS + coefficient.
- R6: The key write address is index*(3*COEFS/2) + pair*3 + byte. Every address of each buffer, from 0 to HALF_POLYS*3*COEFS/2-1, is written exactly once, in increasing order.
- R7: Each source coefficient is read exactly once per run. No read is issued in the cycle that writes the middle byte of a pair. The data is consumed the cycle after its read.
- R8: `busy` is high for exactly 1 + 2*HALF_POLYS*3*COEFS/2 cycles. `done` is high for exactly one cycle, the first cycle after the last byte, when `busy` is already low.
- R9: A `start` pulse while `busy` is high is ignored. The run neither restarts nor lengthens, and its output stays correct.
- R10: A new `start` after `done` runs a full new pass from polynomial 0 on the current source contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (sampled only when idle) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after the last byte |
| src_rd_en | output | 1 | Source read request |
| src_rd_sel | output | 1 | Source region: 0 public, 1 secret |
| src_rd_addr | output | 9 | Coefficient address within the region |
| src_rd_data | input | 12 | Registered read data, valid the cycle after `src_rd_en` |
| key_wr_en | output | 1 | Key buffer byte write |
| key_wr_sel | output | 1 | Target buffer: 0 public, 1 secret |
| key_wr_addr | output | 10 | Byte address within the target buffer |
| key_wr_data | output | 8 | Packed byte |

## Verification
The riskiest corner is the read skew. If the first coefficient of a pair is fetched one cycle late, or its top nibble is not held until the middle byte, the middle and last bytes pick up the wrong coefficient. Saturated and checkerboard data would expose this. The region boundary is aimed at next: a design that keeps reading the public region after polynomial `HALF_POLYS-1`, or that fails to restart the address at zero in the secret buffer, would miss or duplicate secret-buffer addresses. A restart caused by `start` in mid-pass would show up as an extra `done`, a longer `busy` window and more than one write to some addresses. A second pass checks that the counters return cleanly to polynomial 0.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  localparam int COEF_W       = 12;
  localparam int BYTE_W       = 8;
  localparam int BYTES_IN_PAIR = 3;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_PRIME = 2'd1,
    S_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cbp_seq.sv
// Polynomial / pair / byte walker and read scheduler.
module cbp_seq #(
  parameter int NPOLY  = 4,
  parameter int PAIRS  = 128,
  parameter int POLY_W = 2,
  parameter int PAIR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic              rd_hi,
  output logic [POLY_W-1:0] rd_poly,
  output logic [PAIR_W-1:0] rd_pair,
  output logic              wr_en,
  output logic [POLY_W-1:0] cur_poly,
  output logic [PAIR_W-1:0] cur_pair,
  output logic [1:0]        cur_byte
);
  import cbp_pkg::*;

  seq_state_e        st_q, st_d;
  logic [POLY_W-1:0] poly_q, poly_d;
  logic [PAIR_W-1:0] pair_q, pair_d;
  logic [1:0]        byte_q, byte_d;
  logic              done_q, done_d;
  logic              ce;
  logic              last_pair, last_poly;

  assign last_pair = (pair_q == PAIR_W'(PAIRS - 1));
  assign last_poly = (poly_q == POLY_W'(NPOLY - 1));
  assign ce        = (st_q != S_IDLE) || start;

  always_comb begin
    st_d    = st_q;
    poly_d  = poly_q;
    pair_d  = pair_q;
    byte_d  = byte_q;
    done_d  = 1'b0;
    rd_en   = 1'b0;
    rd_hi   = 1'b0;
    rd_poly = poly_q;
    rd_pair = pair_q;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d   = S_PRIME;
          poly_d = '0;
          pair_d = '0;
          byte_d = 2'd0;
        end
      end
      S_PRIME: begin
        // fetch the even coefficient of the very first pair
        rd_en = 1'b1;
        st_d  = S_RUN;
      end
      S_RUN: begin
        unique case (byte_q)
          2'd0: begin
            // odd coefficient of this pair
            rd_en  = 1'b1;
            rd_hi  = 1'b1;
            byte_d = 2'd1;
          end
          2'd1: begin
            byte_d = 2'd2;
          end
          2'd2: begin
            byte_d = 2'd0;
            if (last_pair && last_poly) begin
              st_d   = S_IDLE;
              done_d = 1'b1;
            end else begin
              if (last_pair) begin
                pair_d = '0;
                poly_d = poly_q + POLY_W'(1);
              end else begin
                pair_d = pair_q + PAIR_W'(1);
              end
              // even coefficient of the following pair
              rd_en   = 1'b1;
              rd_poly = poly_d;
              rd_pair = pair_d;
            end
          end
          default: begin
            byte_d = 2'd0;
            st_d   = S_IDLE;
          end
        endcase
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      poly_q <= '0;
      pair_q <= '0;
      byte_q <= 2'd0;
      done_q <= 1'b0;
    end else begin
      if (ce) begin
        st_q   <= st_d;
        poly_q <= poly_d;
        pair_q <= pair_d;
        byte_q <= byte_d;
      end
      done_q <= done_d;
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign wr_en    = (st_q == S_RUN);
  assign cur_poly = poly_q;
  assign cur_pair = pair_q;
  assign cur_byte = byte_q;
endmodule

// File: rtl/cbp_region_map.sv
// Splits a running polynomial number into region select and index.
module cbp_region_map #(
  parameter int HALF_POLYS = 2,
  parameter int POLY_W     = 2
) (
  input  logic [POLY_W-1:0] poly,
  output logic              hi,
  output logic [POLY_W-1:0] idx
);
  localparam logic [POLY_W-1:0] HALF_V = POLY_W'(HALF_POLYS);

  always_comb begin
    hi  = (poly >= HALF_V);
    idx = hi ? (poly - HALF_V) : poly;
  end
endmodule

// File: rtl/cbp_form.sv
// Byte formation: holds the parts of a pair that outlive the read data.
module cbp_form (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  byte_sel,
  input  logic [11:0] rd_data,
  output logic [7:0]  wr_data
);
  logic [3:0] c0_top_q;
  logic [7:0] c1_top_q;
  logic       cap_c0, cap_c1;

  assign cap_c0 = wr_en && (byte_sel == 2'd0);
  assign cap_c1 = wr_en && (byte_sel == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_top_q <= '0;
      c1_top_q <= '0;
    end else begin
      if (cap_c0) c0_top_q <= rd_data[11:8];
      if (cap_c1) c1_top_q <= rd_data[11:4];
    end
  end

  always_comb begin
    unique case (byte_sel)
      2'd0:    wr_data = rd_data[7:0];
      2'd1:    wr_data = {rd_data[3:0], c0_top_q};
      default: wr_data = c1_top_q;
    endcase
  end
endmodule

// File: rtl/coef_byte_packer.sv
module coef_byte_packer #(
  parameter int HALF_POLYS = 2,
  parameter int COEFS      = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic         src_rd_en,
  output logic         src_rd_sel,
  output logic [$clog2(HALF_POLYS*COEFS)-1:0] src_rd_addr,
  input  logic [11:0]  src_rd_data,
  output logic         key_wr_en,
  output logic         key_wr_sel,
  output logic [$clog2(HALF_POLYS*(COEFS/2)*3)-1:0] key_wr_addr,
  output logic [7:0]   key_wr_data
);
  localparam int NPOLY  = 2 * HALF_POLYS;
  localparam int PAIRS  = COEFS / 2;
  localparam int PBYTES = PAIRS * cbp_pkg::BYTES_IN_PAIR;
  localparam int POLY_W = $clog2(NPOLY);
  localparam int PAIR_W = $clog2(PAIRS);
  localparam int RD_AW  = $clog2(HALF_POLYS * COEFS);
  localparam int WR_AW  = $clog2(HALF_POLYS * PBYTES);

  logic              rd_hi;
  logic [POLY_W-1:0] rd_poly, cur_poly, rd_idx, wr_idx;
  logic [PAIR_W-1:0] rd_pair, cur_pair;
  logic [1:0]        cur_byte;
  logic              wr_en_w;

  cbp_seq #(
    .NPOLY (NPOLY),
    .PAIRS (PAIRS),
    .POLY_W(POLY_W),
    .PAIR_W(PAIR_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_en   (src_rd_en),
    .rd_hi   (rd_hi),
    .rd_poly (rd_poly),
    .rd_pair (rd_pair),
    .wr_en   (wr_en_w),
    .cur_poly(cur_poly),
    .cur_pair(cur_pair),
    .cur_byte(cur_byte)
  );

  cbp_region_map #(.HALF_POLYS(HALF_POLYS), .POLY_W(POLY_W)) u_rd_map (
    .poly(rd_poly),
    .hi  (src_rd_sel),
    .idx (rd_idx)
  );

  cbp_region_map #(.HALF_POLYS(HALF_POLYS), .POLY_W(POLY_W)) u_wr_map (
    .poly(cur_poly),
    .hi  (key_wr_sel),
    .idx (wr_idx)
  );

  always_comb begin
    src_rd_addr = RD_AW'(32'(rd_idx) * 32'(COEFS) + 32'({rd_pair, rd_hi}));
    key_wr_addr = WR_AW'(32'(wr_idx) * 32'(PBYTES)
                       + 32'(cur_pair) * 32'(cbp_pkg::BYTES_IN_PAIR)
                       + 32'(cur_byte));
  end

  cbp_form u_form (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_w),
    .byte_sel(cur_byte),
    .rd_data (src_rd_data),
    .wr_data (key_wr_data)
  );

  assign key_wr_en = wr_en_w;
endmodule

// File: rtl/cbp_chk.sv
module cbp_chk #(
  parameter int WR_AW = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             rd_en,
  input logic             rd_sel,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [WR_AW-1:0] wr_addr,
  input logic [1:0]       wr_byte
);
  // R1: idle means no memory traffic
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_en && !wr_en));

  // R7: middle byte cycle leaves the read port free
  p_mid_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte == 2'd1) |-> !rd_en);

  // R5: odd coefficient was read one cycle earlier from the matching region
  p_src_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte == 2'd1) |-> ($past(rd_en) && ($past(rd_sel) == wr_sel)));

  // R6: addresses climb by one inside a target buffer
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && (wr_sel == $past(wr_sel)))
      |-> (wr_addr == $past(wr_addr) + WR_AW'(1)));

  // R6: a pass opens at address 0 of the public buffer
  p_first_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(wr_en)) |-> (wr_addr == '0 && !wr_sel));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done follows the last secret-buffer byte with busy already low
  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(wr_en) && $past(wr_sel)));

  // R7: a pass opens with a priming read and no write
  p_prime_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rd_en && !wr_en));
endmodule

bind coef_byte_packer cbp_chk #(.WR_AW(WR_AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .done   (done),
  .rd_en  (src_rd_en),
  .rd_sel (src_rd_sel),
  .wr_en  (key_wr_en),
  .wr_sel (key_wr_sel),
  .wr_addr(key_wr_addr),
  .wr_byte(cur_byte)
);

// File: tb/coef_byte_packer_test.sv
`timescale 1ns/1ps
module coef_byte_packer_test;
  localparam int HALF   = 2;
  localparam int COEFS  = 256;
  localparam int PBYTES = COEFS / 2 * 3;
  localparam int RWORDS = HALF * COEFS;
  localparam int BWORDS = HALF * PBYTES;
  localparam int BUSY_EXP = 1 + 2 * HALF * PBYTES;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        busy, done;
  logic        src_rd_en, src_rd_sel;
  logic [8:0]  src_rd_addr;
  logic [11:0] src_rd_data;
  logic        key_wr_en, key_wr_sel;
  logic [9:0]  key_wr_addr;
  logic [7:0]  key_wr_data;

  always #4 clk = ~clk;  // 125 MHz

  coef_byte_packer #(.HALF_POLYS(HALF), .COEFS(COEFS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .src_rd_en(src_rd_en), .src_rd_sel(src_rd_sel), .src_rd_addr(src_rd_addr),
    .src_rd_data(src_rd_data), .key_wr_en(key_wr_en), .key_wr_sel(key_wr_sel),
    .key_wr_addr(key_wr_addr), .key_wr_data(key_wr_data)
  );

  // source storage model: one port, registered read
  logic [11:0] pub_src [RWORDS];
  logic [11:0] sec_src [RWORDS];
  always @(posedge clk)
    if (src_rd_en) src_rd_data <= src_rd_sel ? sec_src[src_rd_addr] : pub_src[src_rd_addr];

  logic [7:0] pub_buf [BWORDS];
  logic [7:0] sec_buf [BWORDS];
  int         pub_wc  [BWORDS];
  int         sec_wc  [BWORDS];

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] gen(input int mode, input int region, input int idx);
    int h;
    case (mode)
      0: gen = 12'((idx * 7 + region * 1000 + 3) & 12'hFFF);
      1: gen = (region == 0) ? 12'hFFF : 12'h001;
      2: gen = ((idx & 1) != 0) ? ((region == 0) ? 12'hA5C : 12'h35A)
                                : ((region == 0) ? 12'h5A3 : 12'hCA5);
      default: begin
        h   = idx * 40503 + region * 977 + 12345;
        h   = h ^ (h >>> 7);
        gen = 12'(h * 31);
      end
    endcase
  endfunction

  task automatic fill(input int mode);
    for (int i = 0; i < RWORDS; i++) begin
      pub_src[i] = gen(mode, 0, i);
      sec_src[i] = gen(mode, 1, i);
    end
  endtask

  // one pass: drives start, captures every write, checks all outputs
  task automatic t_pass(input int mode, input int poke, input string tag);
    int busy_cnt = 0, rd0 = 0, rd1 = 0, mid_rd = 0, done_cnt = 0;
    int order_bad = 0, wc_bad = 0, last_pub = -1, last_sec = -1;
    int m0 = 0, m1 = 0, m2 = 0, msec = 0;
    bit finished = 0, busy_at_done = 1, done_after = 1;
    fill(mode);
    for (int i = 0; i < BWORDS; i++) begin
      pub_wc[i] = 0; sec_wc[i] = 0; pub_buf[i] = 8'h00; sec_buf[i] = 8'h00;
    end
    @(negedge clk);
    start = 1'b1;
    for (int cyc = 0; cyc < 5000 && !finished; cyc++) begin
      @(negedge clk);
      start = (cyc == poke);
      if (busy) busy_cnt++;
      if (src_rd_en) begin
        if (src_rd_sel) rd1++; else rd0++;
      end
      if (key_wr_en) begin
        if (src_rd_en && (int'(key_wr_addr) % 3 == 1)) mid_rd++;
        if (key_wr_sel) begin
          sec_buf[key_wr_addr] = key_wr_data; sec_wc[key_wr_addr]++;
          if (int'(key_wr_addr) != last_sec + 1) order_bad++;
          last_sec = int'(key_wr_addr);
        end else begin
          pub_buf[key_wr_addr] = key_wr_data; pub_wc[key_wr_addr]++;
          if (int'(key_wr_addr) != last_pub + 1) order_bad++;
          last_pub = int'(key_wr_addr);
        end
      end
      if (done) begin
        done_cnt++;
        busy_at_done = busy;
        @(negedge clk);
        done_after = done;
        finished = 1;
      end
    end
    start = 1'b0;
    chk(finished, "R8", {tag, " watchdog: pass finished"}, finished, 1);
    // expected bytes computed from the source arrays
    for (int r = 0; r < 2; r++)
      for (int p = 0; p < HALF; p++)
        for (int q = 0; q < COEFS / 2; q++) begin
          logic [11:0] c0, c1;
          logic [7:0]  e0, e1, e2, a0, a1, a2;
          int          b;
          c0 = (r == 0) ? pub_src[p * COEFS + 2 * q] : sec_src[p * COEFS + 2 * q];
          c1 = (r == 0) ? pub_src[p * COEFS + 2 * q + 1] : sec_src[p * COEFS + 2 * q + 1];
          e0 = c0[7:0];
          e1 = {c1[3:0], c0[11:8]};
          e2 = c1[11:4];
          b  = p * PBYTES + 3 * q;
          a0 = (r == 0) ? pub_buf[b] : sec_buf[b];
          a1 = (r == 0) ? pub_buf[b + 1] : sec_buf[b + 1];
          a2 = (r == 0) ? pub_buf[b + 2] : sec_buf[b + 2];
          if (a0 != e0) begin
            if (m0 == 0) $display("  first byte0 mismatch at %0d: got %h exp %h", b, a0, e0);
            m0++;
          end
          if (a1 != e1) m1++;
          if (a2 != e2) m2++;
          if (r == 1 && (a0 != e0 || a1 != e1 || a2 != e2)) msec++;
        end
    for (int i = 0; i < BWORDS; i++) begin
      if (pub_wc[i] != 1) wc_bad++;
      if (sec_wc[i] != 1) wc_bad++;
    end
    chk(m0 == 0, "R2", {tag, " first-byte mismatches"}, m0, 0);
    chk(m1 == 0, "R3", {tag, " middle-byte mismatches"}, m1, 0);
    chk(m2 == 0, "R4", {tag, " last-byte mismatches"}, m2, 0);
    chk(msec == 0, "R5", {tag, " secret-buffer pair mismatches"}, msec, 0);
    chk(rd0 == RWORDS && rd1 == RWORDS, "R5", {tag, " reads per region (public)"}, rd0, RWORDS);
    chk(wc_bad == 0, "R6", {tag, " addresses not written exactly once"}, wc_bad, 0);
    chk(order_bad == 0, "R6", {tag, " out-of-order writes"}, order_bad, 0);
    chk(rd0 + rd1 == 2 * RWORDS, "R7", {tag, " total reads"}, rd0 + rd1, 2 * RWORDS);
    chk(mid_rd == 0, "R7", {tag, " reads during middle byte"}, mid_rd, 0);
    chk(busy_cnt == BUSY_EXP, "R8", {tag, " busy cycles"}, busy_cnt, BUSY_EXP);
    chk(done_cnt == 1, "R8", {tag, " done pulses"}, done_cnt, 1);
    chk(!busy_at_done, "R8", {tag, " busy when done high"}, busy_at_done, 0);
    chk(!done_after, "R8", {tag, " done one cycle later"}, done_after, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
    chk(!src_rd_en && !key_wr_en, "R1", "rd/wr enables in reset", {src_rd_en, key_wr_en}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !src_rd_en && !key_wr_en, "R1", "idle after reset release",
        {busy, done, src_rd_en, key_wr_en}, 0);
  endtask

  task automatic t_incrementing;   t_pass(0, -1, "R2/inc");      endtask
  task automatic t_saturated;      t_pass(1, -1, "R3/sat");      endtask
  task automatic t_checkerboard;   t_pass(2, -1, "R4/chk");      endtask
  task automatic t_start_midpass;  t_pass(3, 200, "R9/poke");    endtask
  task automatic t_start_late;     t_pass(0, 1500, "R9/latepoke"); endtask
  task automatic t_back_to_back;   t_pass(2, -1, "R10/second");  endtask

  initial begin
    t_reset();
    t_incrementing();
    t_saturated();
    t_checkerboard();
    t_start_midpass();
    t_start_late();
    t_back_to_back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R8 watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end
endmodule